// File: doc/BRIEF.md
# Delta-Sigma ADC Result Fetch Sequencer

This block is an SPI master that pulls conversion results out of an external delta-sigma converter. It watches the converter's active-low ready line. When a falling edge shows that a new conversion is waiting, the block lowers chip select and sends the read command. It then holds the bus quiet for a turnaround interval, which is measured in converter oscillator periods and converted into system clocks. After that it clocks in a 24-bit two's-complement word and raises chip select again.

The received word is widened to 32 bits by sign extension and presented with a one-cycle strobe. The converter's digital filter produces one bad sample after every restart. For this reason the block silently drops the first completed read after reset, and also the first read after a `restart` pulse. A ready edge that arrives while a transaction is still running is not queued.

Top module: `adc_result_fetch`

## Requirements
- R1: A transaction begins only on a high-to-low transition of `conv_rdy_n` seen while the block is idle. A steady level, high or low, starts nothing.
- R2: Each transaction first sends the byte 0x01 on `mosi`, most significant bit first. `mosi` changes on rising `sclk` edges and is meant to be sampled on falling edges.
- R3: From the last falling `sclk` edge of the command byte to the first rising edge of the data phase, at least ceil(GAP_OSC × OSC_NUM / OSC_DEN) system clocks elapse. With the defaults this is 125 clocks.
- R4: The data phase consists of 24 `sclk` cycles. `miso` is sampled on each falling edge, first bit = bit 23, so that a chip-select window holds exactly 32 rising `sclk` edges.
- R5: `cs_n` stays low without a break from the first command edge to the last data edge. Between windows it stays high for at least ceil(SPACE_OSC × OSC_NUM / OSC_DEN) system clocks, which is 10 with the defaults. `busy` is high whenever `cs_n` is low.
- R6: A reported `result` equals the received 24-bit word, with bit 23 copied into bits 31 to 24.
- R7: `result_vld` is high for exactly one clock per reported transaction, and only after `cs_n` has returned high. `result` changes only on that cycle.
- R8: The first transaction that starts after reset, or after a `restart` pulse, produces no strobe and leaves `result` unchanged. A `restart` during a running transaction does not suppress that transaction; it suppresses the next one.
- R9: A `conv_rdy_n` falling edge that occurs while `busy` is high is ignored. No new transaction follows from it once the block returns to idle.
- R10: `sclk` is low whenever `cs_n` is high.
- R11: Asserting `rst_n` low forces `cs_n` high, `sclk` low and `busy` low at once, without waiting for a clock. `result` and `result_vld` reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released in step with `clk` |
| conv_rdy_n | input | 1 | Converter ready line, active low, asynchronous to `clk` |
| restart | input | 1 | One-clock pulse marking a converter restart; the next read is dropped |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select to the converter, active low |
| mosi | output | 1 | Serial data to the converter |
| result | output | 32 | Last reported conversion, sign-extended |
| result_vld | output | 1 | One-clock strobe marking a new `result` |
| busy | output | 1 | High from transaction start to the end of the chip-select spacing |

## Verification
Several kinds of internal fault show up at the ports within a single transaction:
- A bit counter that is off by one changes the number of rising `sclk` edges inside the chip-select window. It also shifts the captured word, so the very next strobe carries a wrong value.
- A turnaround timer loaded with a short value shows up as a gap below 125 clocks at the ninth rising edge.
- A drop flag that is wrongly cleared or set makes a strobe appear, or go missing, on the first read after a reset or `restart`.

A mishandled ready edge during `busy` is different: it shows up only after the block returns to idle, as an extra `cs_n` window with no matching ready edge.

// File: rtl/arf_pkg.sv
package arf_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CMD,
    S_GAP,
    S_DATA,
    S_DONE,
    S_SPACE
  } arf_state_e;

  localparam logic [7:0] READ_CMD = 8'h01;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/arf_sclk_gen.sv
module arf_sclk_gen #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          tick;

  assign tick = run && (cnt_q == CW'(HALF - 1));
  assign rise = tick && !sclk_q;
  assign fall = tick && sclk_q;
  assign sclk = sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

endmodule

// File: rtl/arf_shift.sv
module arf_shift #(
  parameter int TXW = 8,
  parameter int RXW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [TXW-1:0] load_val,
  input  logic           quiet,
  input  logic           rise,
  input  logic           fall,
  input  logic           miso,
  output logic           mosi,
  output logic [RXW-1:0] rx_word
);
  logic [TXW-1:0] tx_q, tx_d;
  logic           mosi_q, mosi_d;
  logic [RXW-1:0] rx_q, rx_d;

  always_comb begin
    tx_d   = tx_q;
    mosi_d = mosi_q;
    rx_d   = rx_q;
    if (load) begin
      tx_d   = load_val;
      mosi_d = 1'b0;
    end else if (rise && !quiet) begin
      mosi_d = tx_q[TXW-1];
      tx_d   = {tx_q[TXW-2:0], 1'b0};
    end else if (quiet) begin
      mosi_d = 1'b0;
    end
    if (fall) begin
      rx_d = {rx_q[RXW-2:0], miso};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      mosi_q <= 1'b0;
      rx_q   <= '0;
    end else begin
      tx_q   <= tx_d;
      mosi_q <= mosi_d;
      rx_q   <= rx_d;
    end
  end

  assign mosi    = mosi_q;
  assign rx_word = rx_q;

endmodule

// File: rtl/arf_interval.sv
module arf_interval #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt_q, cnt_d;

  assign expired = (cnt_q == '0);

  always_comb begin
    if (load)               cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - W'(1);
    else                    cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/adc_result_fetch.sv
module adc_result_fetch #(
  parameter int SCLK_HALF  = 2,
  parameter int OSC_NUM    = 5,
  parameter int OSC_DEN    = 2,
  parameter int GAP_OSC    = 50,
  parameter int SPACE_OSC  = 4,
  parameter int RES_W      = 24,
  parameter int OUT_W      = 32,
  parameter bit DISCARD_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_rdy_n,
  input  logic             restart,
  input  logic             miso,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  output logic [OUT_W-1:0] result,
  output logic             result_vld,
  output logic             busy
);
  import arf_pkg::*;

  localparam int GAP_CLKS   = ceil_div(GAP_OSC * OSC_NUM, OSC_DEN);
  localparam int SPACE_CLKS = ceil_div(SPACE_OSC * OSC_NUM, OSC_DEN);
  localparam int TMAX       = (GAP_CLKS > SPACE_CLKS) ? GAP_CLKS : SPACE_CLKS;
  localparam int TW         = $clog2(TMAX + 1);
  localparam int CMD_W      = 8;
  localparam int BW         = $clog2(RES_W + 1);
  localparam int EXT_W      = OUT_W - RES_W;

  // reset: asserted at once, released after two clocks
  logic [1:0] rst_pipe;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i = rst_pipe[1];

  // ready line synchroniser and edge detect
  logic [2:0] rdy_s;
  logic       rdy_fall;

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) rdy_s <= 3'b111;
    else        rdy_s <= {rdy_s[1:0], conv_rdy_n};
  end
  assign rdy_fall = rdy_s[2] & ~rdy_s[1];

  arf_state_e             state_q, state_d;
  logic [BW-1:0]          bits_q, bits_d;
  logic                   pend_q, pend_d;
  logic                   drop_q, drop_d;
  logic [OUT_W-1:0]       res_q, res_d;
  logic                   vld_q, vld_d;
  logic                   cs_n_q, cs_n_d;

  logic                   run, s_rise, s_fall;
  logic                   sh_ld, quiet;
  logic [RES_W-1:0]       rx_word;
  logic                   tmr_ld, tmr_exp;
  logic [TW-1:0]          tmr_val;
  logic                   start;

  assign run   = (state_q == S_CMD) || (state_q == S_DATA);
  assign quiet = (state_q != S_CMD);
  assign start = (state_q == S_IDLE) && rdy_fall;

  arf_sclk_gen #(.HALF(SCLK_HALF)) u_sclk (
    .clk  (clk),
    .rst_n(rst_i),
    .run  (run),
    .sclk (sclk),
    .rise (s_rise),
    .fall (s_fall)
  );

  arf_shift #(.TXW(CMD_W), .RXW(RES_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_i),
    .load    (sh_ld),
    .load_val(READ_CMD),
    .quiet   (quiet),
    .rise    (s_rise),
    .fall    (s_fall),
    .miso    (miso),
    .mosi    (mosi),
    .rx_word (rx_word)
  );

  arf_interval #(.W(TW)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_i),
    .load    (tmr_ld),
    .load_val(tmr_val),
    .expired (tmr_exp)
  );

  always_comb begin
    state_d = state_q;
    bits_d  = bits_q;
    res_d   = res_q;
    vld_d   = 1'b0;
    sh_ld   = 1'b0;
    tmr_ld  = 1'b0;
    tmr_val = TW'(GAP_CLKS);
    unique case (state_q)
      S_IDLE: begin
        if (rdy_fall) begin
          state_d = S_CMD;
          sh_ld   = 1'b1;
          bits_d  = BW'(CMD_W);
        end
      end
      S_CMD: begin
        if (s_fall) begin
          bits_d = bits_q - BW'(1);
          if (bits_q == BW'(1)) begin
            state_d = S_GAP;
            tmr_ld  = 1'b1;
            tmr_val = TW'(GAP_CLKS);
          end
        end
      end
      S_GAP: begin
        if (tmr_exp) begin
          state_d = S_DATA;
          bits_d  = BW'(RES_W);
        end
      end
      S_DATA: begin
        if (s_fall) begin
          bits_d = bits_q - BW'(1);
          if (bits_q == BW'(1)) state_d = S_DONE;
        end
      end
      S_DONE: begin
        if (!drop_q) begin
          res_d = {{EXT_W{rx_word[RES_W-1]}}, rx_word};
          vld_d = 1'b1;
        end
        tmr_ld  = 1'b1;
        tmr_val = TW'(SPACE_CLKS);
        state_d = S_SPACE;
      end
      S_SPACE: begin
        if (tmr_exp) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    if (restart)    pend_d = 1'b1;
    else if (start) pend_d = 1'b0;
    else            pend_d = pend_q;
    drop_d = start ? pend_q : drop_q;
    cs_n_d = !((state_d == S_CMD) || (state_d == S_GAP) || (state_d == S_DATA));
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= S_IDLE;
      bits_q  <= '0;
      pend_q  <= DISCARD_EN;
      drop_q  <= 1'b0;
      res_q   <= '0;
      vld_q   <= 1'b0;
      cs_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      bits_q  <= bits_d;
      pend_q  <= pend_d;
      drop_q  <= drop_d;
      res_q   <= res_d;
      vld_q   <= vld_d;
      cs_n_q  <= cs_n_d;
    end
  end

  assign cs_n       = cs_n_q;
  assign result     = res_q;
  assign result_vld = vld_q;
  assign busy       = (state_q != S_IDLE);

endmodule

// File: rtl/arf_chk.sv
module arf_chk #(
  parameter int GAP_CLKS   = 125,
  parameter int SPACE_CLKS = 10,
  parameter int OUT_W      = 32,
  parameter int RES_W      = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             sclk,
  input logic             busy,
  input logic             result_vld,
  input logic [OUT_W-1:0] result
);
  logic        sclk_d;
  logic [15:0] rises, since_fall, hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b0;
      rises      <= '0;
      since_fall <= '1;
      hi_cnt     <= '1;
    end else begin
      sclk_d <= sclk;
      if (cs_n)                rises <= '0;
      else if (sclk && !sclk_d) rises <= rises + 16'd1;
      if (!sclk && sclk_d)         since_fall <= '0;
      else if (since_fall != '1)   since_fall <= since_fall + 16'd1;
      if (!cs_n)               hi_cnt <= '0;
      else if (hi_cnt != '1)   hi_cnt <= hi_cnt + 16'd1;
    end
  end

  AST_CMD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && sclk && !sclk_d && rises == 16'd8) |-> (since_fall >= 16'(GAP_CLKS))); // R3

  AST_CS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (hi_cnt >= 16'(SPACE_CLKS))); // R5

  AST_BUSY_COVERS_CS: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R5

  AST_SIGN_EXTEND: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> (result[OUT_W-1:RES_W] == {(OUT_W-RES_W){result[RES_W-1]}})); // R6

  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |=> !result_vld); // R7

  AST_VLD_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    result_vld |-> cs_n); // R7

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> result_vld); // R7

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R10

endmodule

bind adc_result_fetch arf_chk #(
  .GAP_CLKS  (GAP_CLKS),
  .SPACE_CLKS(SPACE_CLKS),
  .OUT_W     (OUT_W),
  .RES_W     (RES_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cs_n      (cs_n),
  .sclk      (sclk),
  .busy      (busy),
  .result_vld(result_vld),
  .result    (result)
);

// File: tb/sim_adc_result_fetch.sv
module sim_adc_result_fetch;
  localparam int CLK_PERIOD = 10;
  localparam int GAP_EXP    = 125;  // 50 periods of 2.5 clocks, rounded up
  localparam int SPACE_EXP  = 10;   // 4 periods of 2.5 clocks

  typedef struct packed {
    logic [23:0] raw;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{raw: 24'h00002A, exp: 32'h0000002A},
    '{raw: 24'h7FFFFF, exp: 32'h007FFFFF},
    '{raw: 24'h800000, exp: 32'hFF800000},
    '{raw: 24'hFFFFFF, exp: 32'hFFFFFFFF},
    '{raw: 24'h55002A, exp: 32'h0055002A},
    '{raw: 24'hABCDEF, exp: 32'hFFABCDEF}
  };

  logic        clk = 1'b0;
  logic        rst_n, conv_rdy_n, restart, miso;
  logic        sclk, cs_n, mosi, result_vld, busy;
  logic [31:0] result;

  int n_chk = 0;
  int n_fail = 0;

  adc_result_fetch u0 (
    .clk(clk), .rst_n(rst_n), .conv_rdy_n(conv_rdy_n), .restart(restart),
    .miso(miso), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .result(result), .result_vld(result_vld), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // converter model
  logic [23:0] adc_word = '0;
  logic [7:0]  cmd_seen;
  int   rise_n, fall_n, frame_rises, cs_falls = 0;
  time  t_cmd_end, gap_time, t_cs_rise, min_hi = 1000000;
  bit   seen_rise = 0;
  int   sclk_idle_bad = 0, vld_cs_bad = 0;
  int   vld_cnt = 0;
  logic [31:0] vld_val;

  always @(negedge cs_n) begin
    rise_n = 0; fall_n = 0; cmd_seen = '0; cs_falls++;
    if (seen_rise && ($time - t_cs_rise) < min_hi) min_hi = $time - t_cs_rise;
  end
  always @(posedge cs_n) begin
    frame_rises = rise_n; t_cs_rise = $time; seen_rise = 1;
  end
  always @(posedge sclk) begin
    if (cs_n) sclk_idle_bad++;
    else begin
      if (rise_n == 8) gap_time = $time - t_cmd_end;
      if (rise_n >= 8 && rise_n < 32) miso <= adc_word[23 - (rise_n - 8)];
      rise_n++;
    end
  end
  always @(negedge sclk) begin
    if (!cs_n) begin
      if (fall_n < 8) cmd_seen = {cmd_seen[6:0], mosi};
      if (fall_n == 7) t_cmd_end = $time;
      fall_n++;
    end
  end
  always @(negedge clk) begin
    if (result_vld) begin
      vld_cnt++; vld_val = result;
      if (!cs_n) vld_cs_bad++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 3000) begin @(negedge clk); g++; end
    repeat (3) @(negedge clk);
  endtask

  task automatic begin_conv(input logic [23:0] raw);
    int g = 0;
    adc_word = raw;
    @(negedge clk) conv_rdy_n = 1'b0;
    while (cs_n && g < 100) begin @(negedge clk); g++; end
    conv_rdy_n = 1'b1;
  endtask

  task automatic run_conv(input logic [23:0] raw, input logic [31:0] exp, input bit report);
    int v0 = vld_cnt;
    begin_conv(raw);
    wait_idle();
    chk("R2 command byte", {24'h0, cmd_seen}, 32'h01);
    chk("R3 turnaround gap", {31'h0, gap_time >= GAP_EXP * CLK_PERIOD}, 32'h1);
    chk("R4 sclk edges per window", frame_rises, 32);
    if (report) begin
      chk("R7 one strobe", vld_cnt - v0, 1);
      chk("R6 sign-extended result", vld_val, exp);
    end else begin
      chk("R8 dropped read strobes", vld_cnt - v0, 0);
      chk("R8 result unchanged", result, exp);
    end
  endtask

  initial begin
    int f0;
    rst_n = 1'b0; conv_rdy_n = 1'b1; restart = 1'b0; miso = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk("R11 cs_n at reset", cs_n, 1);
    chk("R11 sclk at reset", sclk, 0);
    chk("R11 busy at reset", busy, 0);
    chk("R11 result at reset", result, 0);
    chk("R11 strobe at reset", result_vld, 0);

    // R1 no activity while ready stays high
    repeat (60) @(negedge clk);
    chk("R1 no start without ready edge", cs_falls, 0);

    // R8 first read after reset is dropped
    run_conv(24'h123456, 32'h0, 1'b0);

    // table walk
    for (int i = 0; i < 6; i++) run_conv(VECS[i].raw, VECS[i].exp, 1'b1);

    // R9 ready edge while busy
    f0 = cs_falls;
    begin_conv(24'h000100);
    repeat (40) @(negedge clk);
    conv_rdy_n = 1'b0;
    repeat (5) @(negedge clk);
    wait_idle();
    repeat (40) @(negedge clk);
    chk("R9 busy ready edge ignored", cs_falls - f0, 1);
    chk("R9 still idle", busy, 0);
    chk("R9 first result kept", result, 32'h00000100);
    conv_rdy_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 low level starts nothing", cs_falls - f0, 1);

    // R8 restart while idle
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    run_conv(24'h000777, 32'h00000100, 1'b0);
    run_conv(24'hFFFF00, 32'hFFFFFF00, 1'b1);

    // R8 restart during a transaction drops the next one only
    f0 = vld_cnt;
    begin_conv(24'h00ABCD);
    @(negedge clk) restart = 1'b1;
    @(negedge clk) restart = 1'b0;
    wait_idle();
    chk("R8 in-flight read reported", vld_cnt - f0, 1);
    chk("R8 in-flight value", vld_val, 32'h0000ABCD);
    run_conv(24'h0F0F0F, 32'h0000ABCD, 1'b0);
    run_conv(24'h800001, 32'hFF800001, 1'b1);

    chk("R5 chip-select spacing", {31'h0, min_hi >= SPACE_EXP * CLK_PERIOD}, 32'h1);
    chk("R10 sclk idle low", sclk_idle_bad, 0);
    chk("R7 strobe only with cs_n high", vld_cs_bad, 0);

    // R11 reset in mid-transaction acts at once
    begin_conv(24'h222222);
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 async cs_n", cs_n, 1);
    chk("R11 async sclk", sclk, 0);
    chk("R11 async busy", busy, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run_conv(24'h000001, 32'h0, 1'b0);
    run_conv(24'h000003, 32'h00000003, 1'b1);

    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

endmodule